// File: doc/BRIEF.md
# Fetch-Path Bit-Set Fault Injector

This block sits on the read path between a memory and whatever consumes the fetched words. It lets a processor model or a testbench reproduce an asymmetric fault in which single bits of a fetched word are forced high. The stored word is never touched. Only the copy that passes through the block is altered, and only during a short, precisely timed window.

Before use, the block is armed with five settings: a cycle delay, a window length, a target bit index, a one-bit or two-adjacent-bit mode, and an unaligned-access flag. A rising edge on the external trigger starts the delay count. When the delay has run out, the selected bits are ORed into the passing word for the window, and the block then disarms itself.

On an unaligned access the halfwords are swapped on the read path, so the target index is rotated by 16. The low half of the word is also faulted one cycle earlier than the high half. A sticky flag and an accumulated mask record what was applied. The corruption is combinational on the incoming word, so it adds no latency.

Top module: `bitset_fault_injector`

## Requirements
- R1: The block can only set bits. `fetchData` equals `rdData | m` for some mask `m`, and an all-ones `rdData` always passes through unchanged.
- R2: While no injection is active, `fetchData` equals `rdData` in the same cycle, with no register in between. A word read after a window passes through unchanged.
- R3: In one-bit mode (`cfgPair`=0) with `cfgUnaligned`=0, only bit `cfgBit` is set during the window.
- R4: In two-bit mode (`cfgPair`=1), bits `cfgBit` and `cfgBit+1` are set. When `cfgBit`=31, bits 31 and 30 are set instead.
- R5: With `cfgUnaligned`=1, every target bit index b (including the neighbour in two-bit mode) is replaced by (b+16) mod 32.
- R6: With `cfgUnaligned`=1 and window length W, the mask bits in 15..0 are applied in window cycles 0..W-1. The mask bits in 31..16 are applied in cycles 1..W, one cycle later.
- R7: Let the trigger first be sampled high at clock edge e0, having been low at the edge before. The window then starts in the cycle after edge e0+`cfgDelay`, and it lasts `cfgWindow` cycles, with 0 treated as 1. In unaligned mode the window runs one extra cycle.
- R8: `armed` rises in the cycle after `armReq` is sampled and falls after the window. Until the block is re-armed, later trigger edges corrupt nothing.
- R9: Only a low-to-high transition of `trigIn` starts the delay. A trigger already held high when the block is armed does not start it.
- R10: `stsHit` and `stsMask` record the OR of all masks applied, one cycle after each applied cycle, and hold until `clrSts`. A cycle with `clrSts` high loads the status with only that cycle's applied mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| armReq | input | 1 | One-cycle pulse that captures the settings and arms the block |
| cfgDelay | input | 16 | Cycles from the trigger edge to the window start |
| cfgWindow | input | 8 | Window length in cycles (0 means 1) |
| cfgBit | input | 5 | Target bit index |
| cfgPair | input | 1 | 1 selects two adjacent bits |
| cfgUnaligned | input | 1 | 1 marks the access as unaligned (halfword swap) |
| trigIn | input | 1 | External trigger, rising edge is used |
| clrSts | input | 1 | Clears the sticky status |
| rdData | input | 32 | Word coming from memory |
| fetchData | output | 32 | Word delivered to the consumer |
| armed | output | 1 | High from arming until the window ends |
| stsHit | output | 1 | Sticky flag: a mask has been applied |
| stsMask | output | 32 | OR of all masks applied since the last clear |

## Verification
The hardest case to reach is the unaligned split window. Its low half and high half must each show up in exactly the right cycle, counted from a trigger edge that is itself delayed by a programmable count. An unaligned pair that straddles bit 15 makes this harder, because it lands on bits 31 and 0.

The stimulus arms the block with random delays, windows, bit indices and modes, then raises the trigger at a known edge. It compares every cycle of the surrounding span against a mask computed from the window phase. Directed runs add the cases a random draw seldom hits:
- bit 31 in pair mode;
- the straddling unaligned pair;
- a zero delay;
- an all-ones word;
- a trigger already high at arming;
- a trigger edge after the one-shot window has ended.

// File: rtl/fi_pkg.sv
package fi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_WAIT  = 2'd2,
    ST_INJ   = 2'd3
  } fiState_e;

  // Strobes from the control to the datapath: which halves of the mask apply now.
  typedef struct packed {
    logic injLo;
    logic injHi;
  } fiStrobe_t;
endpackage

// File: rtl/fi_ctrl.sv
module fi_ctrl
  import fi_pkg::*;
#(
  parameter int DELAY_W = 16,
  parameter int WIN_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               armReq,
  input  logic [DELAY_W-1:0] cfgDelay,
  input  logic [WIN_W-1:0]   cfgWindow,
  input  logic               cfgUnaligned,
  input  logic               trigIn,
  output fiStrobe_t          strobe,
  output logic               armed
);
  localparam int PH_W = WIN_W + 1;

  fiState_e           state;
  logic               trigQ;
  logic [DELAY_W-1:0] dlyQ;
  logic [DELAY_W-1:0] dlyCnt;
  logic [PH_W-1:0]    winEff;
  logic [PH_W-1:0]    ph;
  logic [PH_W-1:0]    lastPh;
  logic               unalQ;
  logic               trigRise;

  assign trigRise = trigIn & ~trigQ;
  // The unaligned window is one cycle longer: the upper half trails the lower half.
  assign lastPh   = unalQ ? winEff : winEff - PH_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      trigQ  <= 1'b0;
      dlyQ   <= '0;
      dlyCnt <= '0;
      winEff <= PH_W'(1);
      ph     <= '0;
      unalQ  <= 1'b0;
    end else begin
      trigQ <= trigIn;
      if (armReq) begin
        state  <= ST_ARMED;
        dlyQ   <= cfgDelay;
        winEff <= (cfgWindow == '0) ? PH_W'(1) : PH_W'(cfgWindow);
        unalQ  <= cfgUnaligned;
        ph     <= '0;
      end else begin
        case (state)
          ST_ARMED: begin
            if (trigRise) begin
              ph <= '0;
              if (dlyQ == '0) begin
                state <= ST_INJ;
              end else begin
                dlyCnt <= dlyQ;
                state  <= ST_WAIT;
              end
            end
          end
          ST_WAIT: begin
            if (dlyCnt == DELAY_W'(1)) state <= ST_INJ;
            else                       dlyCnt <= dlyCnt - DELAY_W'(1);
          end
          ST_INJ: begin
            if (ph == lastPh) state <= ST_IDLE;
            else              ph    <= ph + PH_W'(1);
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strobe.injLo = (state == ST_INJ) && (ph < winEff);
    strobe.injHi = (state == ST_INJ) && (unalQ ? (ph != '0) : (ph < winEff));
  end

  assign armed = (state != ST_IDLE);
endmodule

// File: rtl/fi_datapath.sv
module fi_datapath
  import fi_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      armReq,
  input  logic [$clog2(DATA_W)-1:0] cfgBit,
  input  logic                      cfgPair,
  input  logic                      cfgUnaligned,
  input  fiStrobe_t                 strobe,
  input  logic                      clrSts,
  input  logic [DATA_W-1:0]         rdData,
  output logic [DATA_W-1:0]         fetchData,
  output logic                      stsHit,
  output logic [DATA_W-1:0]         stsMask
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] oneHot;
  logic [DATA_W-1:0] baseMask;
  logic [DATA_W-1:0] rotMask;
  logic [DATA_W-1:0] physMask;
  logic [DATA_W-1:0] halfSel;
  logic [DATA_W-1:0] applied;

  always_comb begin
    oneHot = {{(DATA_W-1){1'b0}}, 1'b1} << cfgBit;
    if (!cfgPair)                              baseMask = oneHot;
    else if (cfgBit == $clog2(DATA_W)'(DATA_W-1)) baseMask = oneHot | (oneHot >> 1);
    else                                       baseMask = oneHot | (oneHot << 1);
  end

  // Halfword swap on the unaligned read path.
  for (genvar i = 0; i < DATA_W; i++) begin : gRot
    assign rotMask[i] = baseMask[(i + HALF) % DATA_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       physMask <= '0;
    else if (armReq) physMask <= cfgUnaligned ? rotMask : baseMask;
  end

  assign halfSel   = {{HALF{strobe.injHi}}, {HALF{strobe.injLo}}};
  assign applied   = physMask & halfSel;
  assign fetchData = rdData | applied;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stsHit  <= 1'b0;
      stsMask <= '0;
    end else if (clrSts) begin
      stsHit  <= |applied;
      stsMask <= applied;
    end else begin
      stsHit  <= stsHit | (|applied);
      stsMask <= stsMask | applied;
    end
  end
endmodule

// File: rtl/bitset_fault_injector.sv
module bitset_fault_injector
  import fi_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DELAY_W = 16,
  parameter int WIN_W   = 8,
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               armReq,
  input  logic [DELAY_W-1:0] cfgDelay,
  input  logic [WIN_W-1:0]   cfgWindow,
  input  logic [IDX_W-1:0]   cfgBit,
  input  logic               cfgPair,
  input  logic               cfgUnaligned,
  input  logic               trigIn,
  input  logic               clrSts,
  input  logic [DATA_W-1:0]  rdData,
  output logic [DATA_W-1:0]  fetchData,
  output logic               armed,
  output logic               stsHit,
  output logic [DATA_W-1:0]  stsMask
);
  fiStrobe_t strobe;

  fi_ctrl #(.DELAY_W(DELAY_W), .WIN_W(WIN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .armReq(armReq), .cfgDelay(cfgDelay),
    .cfgWindow(cfgWindow), .cfgUnaligned(cfgUnaligned), .trigIn(trigIn),
    .strobe(strobe), .armed(armed)
  );

  fi_datapath #(.DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .armReq(armReq), .cfgBit(cfgBit),
    .cfgPair(cfgPair), .cfgUnaligned(cfgUnaligned), .strobe(strobe),
    .clrSts(clrSts), .rdData(rdData), .fetchData(fetchData),
    .stsHit(stsHit), .stsMask(stsMask)
  );
endmodule

// File: rtl/fi_checker.sv
module fi_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              clrSts,
  input logic [DATA_W-1:0] rdData,
  input logic [DATA_W-1:0] fetchData,
  input logic              armed,
  input logic              stsHit,
  input logic [DATA_W-1:0] stsMask
);
  AST_SET_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (fetchData & rdData) == rdData); // R1

  AST_PASS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> fetchData == rdData); // R2

  AST_MAX_TWO_BITS: assert property (@(posedge clk) disable iff (!rstN)
    $countones(fetchData & ~rdData) <= 2); // R4

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    stsHit && !clrSts |=> stsHit); // R10

  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    clrSts && !armed |=> !stsHit && stsMask == '0); // R10
endmodule

bind bitset_fault_injector fi_checker #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .clrSts(clrSts), .rdData(rdData),
  .fetchData(fetchData), .armed(armed), .stsHit(stsHit), .stsMask(stsMask)
);

// File: tb/tb_bitset_fault_injector.sv
module tb_bitset_fault_injector;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        armReq = 1'b0;
  logic [15:0] cfgDelay = '0;
  logic [7:0]  cfgWindow = '0;
  logic [4:0]  cfgBit = '0;
  logic        cfgPair = 1'b0;
  logic        cfgUnaligned = 1'b0;
  logic        trigIn = 1'b0;
  logic        clrSts = 1'b0;
  logic [31:0] rdData = '0;
  logic [31:0] fetchData;
  logic        armed;
  logic        stsHit;
  logic [31:0] stsMask;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bitset_fault_injector dut (
    .clk(clk), .rstN(rstN), .armReq(armReq), .cfgDelay(cfgDelay),
    .cfgWindow(cfgWindow), .cfgBit(cfgBit), .cfgPair(cfgPair),
    .cfgUnaligned(cfgUnaligned), .trigIn(trigIn), .clrSts(clrSts),
    .rdData(rdData), .fetchData(fetchData), .armed(armed),
    .stsHit(stsHit), .stsMask(stsMask)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishUp();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic logic [31:0] baseOf(input int b, input bit pair, input bit unal);
    logic [31:0] m;
    m = 32'h1 << b;
    if (pair) m = (b == 31) ? (m | (m >> 1)) : (m | (m << 1));
    if (unal) m = {m[15:0], m[31:16]};
    return m;
  endfunction

  // Mask expected in window phase ph (ph<0 means before the window).
  function automatic logic [31:0] expMask(input int b, input bit pair, input bit unal,
                                          input int w, input int ph);
    logic [31:0] m;
    int weff;
    m = baseOf(b, pair, unal);
    weff = (w == 0) ? 1 : w;
    if (ph < 0) return '0;
    if (!unal) return (ph < weff) ? m : '0;
    return ((ph < weff) ? (m & 32'h0000FFFF) : '0) |
           ((ph >= 1 && ph <= weff) ? (m & 32'hFFFF0000) : '0);
  endfunction

  task automatic arm(input int d, input int w, input int b, input bit pair, input bit unal);
    @(negedge clk);
    cfgDelay = 16'(d); cfgWindow = 8'(w); cfgBit = 5'(b);
    cfgPair = pair; cfgUnaligned = unal; armReq = 1'b1;
    @(negedge clk);
    armReq = 1'b0;
    #1 chk("R8 armed after arm", {31'b0, armed}, 32'h1);
  endtask

  task automatic runFault(input int d, input int w, input int b, input bit pair,
                          input bit unal, input bit allOnes);
    logic [31:0] acc;
    logic [31:0] m;
    int weff;
    int total;
    acc = '0;
    weff = (w == 0) ? 1 : w;
    total = unal ? weff + 1 : weff;
    arm(d, w, b, pair, unal);
    @(negedge clk);
    trigIn = 1'b1;
    for (int k = 1; k <= d + total + 3; k++) begin
      @(negedge clk);
      if (k == 2) trigIn = 1'b0;
      rdData = allOnes ? 32'hFFFF_FFFF : $urandom;
      #1;
      m = expMask(b, pair, unal, w, k - 1 - d);
      acc |= m;
      if (allOnes)                          chk("R1 all-ones word", fetchData, 32'hFFFF_FFFF);
      else if (k - 1 - d < 0 || k - 1 - d >= total) chk("R2 R7 outside window", fetchData, rdData);
      else if (unal)                        chk("R5 R6 R7 unaligned window", fetchData, rdData | m);
      else if (pair)                        chk("R4 R7 pair window", fetchData, rdData | m);
      else                                  chk("R3 R7 single window", fetchData, rdData | m);
    end
    chk("R8 disarmed after window", {31'b0, armed}, 32'h0);
    chk("R10 sticky mask", stsMask, acc);
    chk("R10 sticky flag", {31'b0, stsHit}, 32'h1);
    @(negedge clk);
    clrSts = 1'b1;
    @(negedge clk);
    clrSts = 1'b0;
    #1 chk("R10 cleared", {31'b0, stsHit} | stsMask, 32'h0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rdData = 32'hA5A5_0F0F;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R8 reset armed", {31'b0, armed}, 32'h0);
    chk("R10 reset status", {31'b0, stsHit} | stsMask, 32'h0);
    chk("R2 reset passthrough", fetchData, rdData);

    // Directed corner cases
    runFault(0, 1, 7, 0, 0, 0);    // zero delay, single bit (R7 R3)
    runFault(5, 3, 31, 1, 0, 0);   // pair at top bit (R4)
    runFault(4, 1, 3, 0, 1, 0);    // unaligned single -> bit 19 (R5 R6)
    runFault(2, 2, 15, 1, 1, 0);   // unaligned pair straddling -> bits 31 and 0 (R5 R6)
    runFault(3, 2, 9, 1, 0, 1);    // all-ones word (R1)

    // R9: trigger already high at arming
    @(negedge clk) trigIn = 1'b1;
    arm(0, 1, 4, 0, 0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      rdData = $urandom;
      #1 chk("R9 held trigger ignored", fetchData, rdData);
    end
    chk("R9 still armed", {31'b0, armed}, 32'h1);
    @(negedge clk) trigIn = 1'b0;
    @(negedge clk) trigIn = 1'b1;
    @(negedge clk);
    rdData = 32'h0;
    #1 chk("R9 rising edge starts window", fetchData, 32'h0000_0010);
    @(negedge clk) trigIn = 1'b0;
    @(negedge clk);
    #1 chk("R8 window over", {31'b0, armed}, 32'h0);

    // R8: one-shot, a new edge without re-arming corrupts nothing
    @(negedge clk) trigIn = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      rdData = $urandom;
      #1 chk("R8 no second shot", fetchData, rdData);
    end
    trigIn = 1'b0;
    @(negedge clk) clrSts = 1'b1;
    @(negedge clk) clrSts = 1'b0;

    // Random runs
    for (int i = 0; i < 40; i++) begin
      runFault(int'($urandom_range(0, 20)), int'($urandom_range(0, 4)),
               int'($urandom_range(0, 31)), bit'($urandom_range(0, 1)),
               bit'($urandom_range(0, 1)), ($urandom_range(0, 9) == 0));
    end
    finishUp();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishUp();
  end
endmodule